// File: doc/BRIEF.md
# Indirect Segment Fetcher

This block walks a queue of 64-bit segment descriptors. Each descriptor names a run of 32-bit command words in memory. The block keeps a read pointer and an end pointer for the active segment. When they are equal, the segment is spent. If indirect mode is on and a descriptor is waiting, the block then takes the next descriptor from its queue.

While the segment still has words, the block issues word reads to a simple request/response memory port, one read in flight at a time. It hands each returned word to the command decoder on a valid/ready stream, in order.

Segments carry a flag that marks them as side buffers. Only segments without that flag move the resume pointer, which records the last read position in the main command buffer. Address translation happens elsewhere: every address on the memory port is the raw address from the descriptor.

Top module: `ib_seg_fetcher`

## Requirements
- R1: After reset, the queue reports empty and not full, no memory request or output word is valid, and the read, end and resume pointers are all zero.
- R2: A descriptor holds the byte address in bits 39:0, the side-buffer flag in bit 41 and the word count in bits 62:42, and bits 40 and 63 are ignored. Loading a descriptor sets the read pointer to the address, the end pointer to the address plus four times the word count, and the side-segment output to the flag.
- R3: A descriptor is loaded only in a cycle where the read pointer equals the end pointer, indirect mode is on and the queue is not empty. Otherwise both pointers keep their values.
- R4: Descriptors are loaded in the order they were pushed, and the words of one segment are fully delivered before those of the next.
- R5: A memory request is valid only while the segment has words left and no read is in flight or held at the output. Its address equals the read pointer, and each accepted request advances the read pointer by 4.
- R6: Each accepted request in a segment without the side-buffer flag sets the resume pointer to the new read pointer. In a flagged segment, the resume pointer is left unchanged.
- R7: A descriptor with a word count of zero leaves the segment spent as soon as it loads, so the next waiting descriptor is loaded on the following cycle.
- R8: The full flag is set when DEPTH descriptors are queued. A push while full is refused and the pushed descriptor is lost, even when a descriptor is loaded in the same cycle.
- R9: Returned words appear on the output stream in request order. A presented word stays valid, with unchanged data, until it is accepted.
- R10: A memory request that is not accepted stays valid, with an unchanged address, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ind_en | input | 1 | Indirect mode enable; gates descriptor loads |
| ent_push_valid | input | 1 | Push a descriptor into the queue |
| ent_push_data | input | 64 | Descriptor being pushed |
| ent_q_full | output | 1 | Queue holds DEPTH descriptors |
| ent_q_empty | output | 1 | Queue holds no descriptor |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Returned word |
| word_valid | output | 1 | Command word valid toward the decoder |
| word_ready | input | 1 | Decoder accepts the word |
| word_data | output | DW | Command word |
| rd_ptr | output | 40 | Read pointer of the active segment |
| end_ptr | output | 40 | End pointer of the active segment |
| main_ptr | output | 40 | Resume pointer of the main buffer |
| seg_non_main | output | 1 | Active segment carries the side-buffer flag |

## Verification
A descriptor push and a descriptor load can land on the same clock edge. The bench provokes this by filling the queue while indirect mode is off. It then turns the mode on in the same cycle that it pushes one more descriptor, which has a distinct address. The load frees a slot at that edge, but the push must still be refused because the queue was full when it was offered. The bench judges this by draining the stream and confirming that the extra address never appears and that the queue ends empty.

// File: rtl/ib_fetch_pkg.sv
// Package: shared widths, descriptor field positions and types for the
// indirect segment fetcher. Field positions follow the descriptor format.
package ib_fetch_pkg;

    localparam int ENT_W    = 64;
    localparam int ADDR_W   = 40;
    localparam int SIZE_W   = 21;
    localparam int NM_BIT   = 41;
    localparam int SIZE_LSB = 42;
    localparam int WORD_B   = 4;

    // Compact descriptor as stored in the queue (reserved bits dropped).
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              non_main;
        logic [ADDR_W-1:0] addr;
    } seg_desc_t;

    localparam int DESC_W = $bits(seg_desc_t);

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_HOLD = 2'd2
    } port_st_t;

    // Byte address one past the last word of a segment.
    function automatic logic [ADDR_W-1:0] seg_end(input logic [ADDR_W-1:0] base,
                                                  input logic [SIZE_W-1:0] words);
        return base + {{(ADDR_W-SIZE_W-2){1'b0}}, words, 2'b00};
    endfunction

endpackage

// File: rtl/ib_entry_queue.sv
// Module: ib_entry_queue
// Circular descriptor queue. A push is taken only while not full; a pop is
// taken only while not empty. The head entry is visible combinationally.
// Assumes DEPTH >= 2.
module ib_entry_queue #(
    parameter int DEPTH = 4,
    parameter int EW    = 62
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          full,
    output logic          empty
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    logic [EW-1:0] store [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;
    logic [CW-1:0] fill;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign push_ok = push_valid && !full;
    assign pop_ok  = pop && !empty;
    assign head    = store[rd_idx];

    // Write the pushed descriptor into its slot.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_idx] <= push_data;
        end
    end

    // Advance indices and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) begin
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (pop_ok) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/ib_seg_tracker.sv
// Module: ib_seg_tracker
// Holds the read, end and resume pointers of the active segment. A load
// replaces the segment; an advance steps the read pointer by one word and,
// for main segments, copies it into the resume pointer. Assumes load and
// advance never coincide (advance needs words left, load needs none).
module ib_seg_tracker
    import ib_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  seg_desc_t         load_desc,
    input  logic              adv,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] end_ptr,
    output logic [ADDR_W-1:0] main_ptr,
    output logic              non_main,
    output logic              seg_done
);

    logic [ADDR_W-1:0] rd_next;

    assign rd_next  = rd_ptr + ADDR_W'(WORD_B);
    assign seg_done = (rd_ptr == end_ptr);

    // Segment pointers: load new bounds or step one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            end_ptr  <= '0;
            non_main <= 1'b0;
        end else if (load) begin
            rd_ptr   <= load_desc.addr;
            end_ptr  <= seg_end(load_desc.addr, load_desc.size);
            non_main <= load_desc.non_main;
        end else if (adv) begin
            rd_ptr   <= rd_next;
        end
    end

    // Resume pointer follows reads of main segments only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_ptr <= '0;
        end else if (adv && !non_main) begin
            main_ptr <= rd_next;
        end
    end

endmodule

// File: rtl/ib_word_port.sv
// Module: ib_word_port
// Issues one word read at a time from the read pointer, waits for its
// response, and holds the word on the output stream until accepted.
// Assumes the memory returns exactly one response per accepted request;
// responses arriving outside the wait state are ignored.
module ib_word_port
    import ib_fetch_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_done,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic              adv,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [DW-1:0]     word_data
);

    port_st_t      st;
    logic [DW-1:0] word_q;

    assign mem_req_valid = (st == PS_IDLE) && !seg_done;
    assign mem_req_addr  = rd_ptr;
    assign adv           = mem_req_valid && mem_req_ready;
    assign word_valid    = (st == PS_HOLD);
    assign word_data     = word_q;

    // Request / wait / hold sequencing for a single word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PS_IDLE;
            word_q <= '0;
        end else begin
            case (st)
                PS_IDLE: if (adv) st <= PS_WAIT;
                PS_WAIT: if (mem_rsp_valid) begin
                    word_q <= mem_rsp_data;
                    st     <= PS_HOLD;
                end
                PS_HOLD: if (word_ready) st <= PS_IDLE;
                default: st <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ib_seg_fetcher.sv
// Module: ib_seg_fetcher
// Top of the indirect segment fetcher: unpacks pushed descriptors, queues
// them, loads the next one when the active segment is spent and indirect
// mode is on, and streams the segment's words from memory in order.
// Assumes a memory port with one response per accepted request.
module ib_seg_fetcher
    import ib_fetch_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_en,
    input  logic              ent_push_valid,
    input  logic [ENT_W-1:0]  ent_push_data,
    output logic              ent_q_full,
    output logic              ent_q_empty,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [DW-1:0]     word_data,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] end_ptr,
    output logic [ADDR_W-1:0] main_ptr,
    output logic              seg_non_main
);

    seg_desc_t         push_desc;
    logic [DESC_W-1:0] q_head;
    seg_desc_t         head_desc;
    logic              seg_done;
    logic              load;
    logic              adv;
    logic              rsvd_unused;

    // Unpack descriptor fields at their fixed positions.
    assign push_desc.addr     = ent_push_data[ADDR_W-1:0];
    assign push_desc.non_main = ent_push_data[NM_BIT];
    assign push_desc.size     = ent_push_data[SIZE_LSB +: SIZE_W];
    assign rsvd_unused        = ^{ent_push_data[ENT_W-1], ent_push_data[ADDR_W]};

    assign head_desc = seg_desc_t'(q_head);
    assign load      = seg_done && ind_en && !ent_q_empty;

    ib_entry_queue #(
        .DEPTH (DEPTH),
        .EW    (DESC_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (ent_push_valid),
        .push_data  (push_desc),
        .pop        (load),
        .head       (q_head),
        .full       (ent_q_full),
        .empty      (ent_q_empty)
    );

    ib_seg_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_desc (head_desc),
        .adv       (adv),
        .rd_ptr    (rd_ptr),
        .end_ptr   (end_ptr),
        .main_ptr  (main_ptr),
        .non_main  (seg_non_main),
        .seg_done  (seg_done)
    );

    ib_word_port #(
        .DW (DW)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .seg_done      (seg_done),
        .rd_ptr        (rd_ptr),
        .adv           (adv),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .word_valid    (word_valid),
        .word_ready    (word_ready),
        .word_data     (word_data)
    );

endmodule

// File: rtl/ib_fetch_chk.sv
// Module: ib_fetch_chk
// Protocol and pointer checks for ib_seg_fetcher, attached by bind.
module ib_fetch_chk
    import ib_fetch_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ind_en,
    input logic              ent_q_full,
    input logic              ent_q_empty,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              word_valid,
    input logic              word_ready,
    input logic [DW-1:0]     word_data,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] end_ptr,
    input logic [ADDR_W-1:0] main_ptr,
    input logic              seg_non_main
);

    a_r5_step_four: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> (rd_ptr == $past(rd_ptr) + ADDR_W'(4)));

    a_r5_req_has_words: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (rd_ptr != end_ptr) && (mem_req_addr == rd_ptr));

    a_r5_no_req_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !mem_req_valid);

    a_r6_main_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !seg_non_main) |=> (main_ptr == rd_ptr));

    a_r6_side_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && seg_non_main) |=> $stable(main_ptr));

    a_r3_no_load_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_en && rd_ptr == end_ptr) |=> ($stable(rd_ptr) && $stable(end_ptr)));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_q_full && ent_q_empty));

    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind ib_seg_fetcher ib_fetch_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ind_en        (ind_en),
    .ent_q_full    (ent_q_full),
    .ent_q_empty   (ent_q_empty),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .word_valid    (word_valid),
    .word_ready    (word_ready),
    .word_data     (word_data),
    .rd_ptr        (rd_ptr),
    .end_ptr       (end_ptr),
    .main_ptr      (main_ptr),
    .seg_non_main  (seg_non_main)
);

// File: tb/ib_seg_fetcher_tb.sv
`timescale 1ns/1ps
// Bench for ib_seg_fetcher: table-driven segments, then directed cases.
module ib_seg_fetcher_tb;

    localparam int DEPTH = 4;
    localparam int DW    = 32;
    localparam int NV    = 4;

    // Stimulus table: base address, word count, side flag, stall mode.
    localparam logic [39:0] TV_ADDR  [NV] = '{40'h00_0000_1000, 40'hAB_CDEF_0100,
                                              40'h00_0000_2000, 40'h12_3456_7FF8};
    localparam logic [20:0] TV_SIZE  [NV] = '{21'd3, 21'd2, 21'd1, 21'd4};
    localparam bit          TV_NM    [NV] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit          TV_STALL [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ind_en;
    logic          ent_push_valid;
    logic [63:0]   ent_push_data;
    logic          ent_q_full;
    logic          ent_q_empty;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [39:0]   mem_req_addr;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;
    logic          word_valid;
    logic          word_ready;
    logic [DW-1:0] word_data;
    logic [39:0]   rd_ptr;
    logic [39:0]   end_ptr;
    logic [39:0]   main_ptr;
    logic          seg_non_main;

    int            total = 0;
    int            bad   = 0;
    int            cyc   = 0;
    int            cap_n = 0;
    logic [DW-1:0] cap_d [64];
    bit            sink_stall = 1'b0;
    bit            mem_stall  = 1'b0;
    bit            rsp_pend   = 1'b0;
    logic [39:0]   rsp_addr   = '0;
    logic [39:0]   exp_main   = '0;

    always #4 clk = ~clk;

    ib_seg_fetcher #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ind_en(ind_en),
        .ent_push_valid(ent_push_valid), .ent_push_data(ent_push_data),
        .ent_q_full(ent_q_full), .ent_q_empty(ent_q_empty),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .word_valid(word_valid),
        .word_ready(word_ready), .word_data(word_data),
        .rd_ptr(rd_ptr), .end_ptr(end_ptr), .main_ptr(main_ptr),
        .seg_non_main(seg_non_main)
    );

    // Memory model and stream sink: readies first, then handshakes seen.
    always @(negedge clk) begin
        cyc++;
        word_ready    = sink_stall ? cyc[0] : 1'b1;
        mem_req_ready = mem_stall  ? cyc[1] : 1'b1;
        if (rsp_pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = ~rsp_addr[DW-1:0];
            rsp_pend      = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            rsp_pend = 1'b1;
            rsp_addr = mem_req_addr;
        end
        if (rst_n && word_valid && word_ready && cap_n < 64) begin
            cap_d[cap_n] = word_data;
            cap_n++;
        end
    end

    function automatic logic [63:0] mk(input logic [39:0] a, input logic [20:0] n,
                                       input bit nm);
        return {1'b0, n, nm, 1'b0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_ent(input logic [63:0] e);
        @(negedge clk);
        ent_push_valid = 1'b1;
        ent_push_data  = e;
        @(negedge clk);
        ent_push_valid = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        for (int k = 0; k < 400 && cap_n < n; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(cap_n == n, req, 64'(cap_n), 64'(n));
    endtask

    task automatic chk_words(input logic [39:0] base, input int first, input int n,
                             input string req);
        for (int k = 0; k < n; k++) begin
            logic [39:0] a;
            a = base + 40'(4 * k);
            chk(cap_d[first + k] == ~a[DW-1:0], req, 64'(cap_d[first + k]),
                64'(~a[DW-1:0]));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] hold_rd;
        logic [39:0] e_end;
        rst_n = 1'b0; ind_en = 1'b0; ent_push_valid = 1'b0; ent_push_data = '0;
        mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0; word_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ent_q_empty == 1'b1, "R1 empty", 64'(ent_q_empty), 64'd1);
        chk(ent_q_full == 1'b0, "R1 full", 64'(ent_q_full), 64'd0);
        chk(mem_req_valid == 1'b0 && word_valid == 1'b0, "R1 valids",
            64'({mem_req_valid, word_valid}), 64'd0);
        chk(rd_ptr == '0 && end_ptr == '0 && main_ptr == '0, "R1 pointers",
            64'(rd_ptr | end_ptr | main_ptr), 64'd0);

        // Table walk: R2 load, R5 requests, R6 resume pointer, R9/R10 under stalls.
        ind_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            cap_n      = 0;
            sink_stall = TV_STALL[i];
            mem_stall  = TV_STALL[i];
            push_ent(mk(TV_ADDR[i], TV_SIZE[i], TV_NM[i]));
            drain(int'(TV_SIZE[i]), "R9 word count");
            chk_words(TV_ADDR[i], 0, int'(TV_SIZE[i]), "R5 R9 word data");
            e_end = TV_ADDR[i] + {17'd0, TV_SIZE[i], 2'b00};
            if (!TV_NM[i]) exp_main = e_end;
            chk(end_ptr == e_end && rd_ptr == e_end, "R2 end pointer", 64'(end_ptr),
                64'(e_end));
            chk(seg_non_main == TV_NM[i], "R2 side flag", 64'(seg_non_main),
                64'(TV_NM[i]));
            chk(main_ptr == exp_main, "R6 resume pointer", 64'(main_ptr), 64'(exp_main));
        end
        sink_stall = 1'b0;
        mem_stall  = 1'b0;

        // R3: no load while indirect mode is off; R2 reserved bits ignored.
        @(negedge clk);
        ind_en  = 1'b0;
        hold_rd = rd_ptr;
        push_ent(mk(40'h00_0000_6000, 21'd2, 1'b0) | 64'h8000_0100_0000_0000);
        repeat (6) @(negedge clk);
        chk(rd_ptr == hold_rd && mem_req_valid == 1'b0, "R3 held off", 64'(rd_ptr),
            64'(hold_rd));
        chk(ent_q_empty == 1'b0, "R3 entry waits", 64'(ent_q_empty), 64'd0);
        cap_n  = 0;
        ind_en = 1'b1;
        drain(2, "R3 resumed count");
        chk_words(40'h00_0000_6000, 0, 2, "R2 R3 reserved bits ignored");
        chk(seg_non_main == 1'b0, "R2 reserved bit 40", 64'(seg_non_main), 64'd0);

        // R4: order across two queued segments.
        @(negedge clk);
        ind_en = 1'b0;
        push_ent(mk(40'h00_0000_7000, 21'd2, 1'b0));
        push_ent(mk(40'h00_0000_7800, 21'd1, 1'b1));
        cap_n  = 0;
        ind_en = 1'b1;
        drain(3, "R4 count");
        chk_words(40'h00_0000_7000, 0, 2, "R4 first segment");
        chk_words(40'h00_0000_7800, 2, 1, "R4 second segment");
        chk(main_ptr == 40'h00_0000_7008, "R6 side segment keeps resume", 64'(main_ptr),
            64'h7008);

        // R7: empty segment is skipped on the next cycle.
        @(negedge clk);
        ind_en = 1'b0;
        push_ent(mk(40'h00_0000_3000, 21'd0, 1'b0));
        push_ent(mk(40'h00_0000_4000, 21'd1, 1'b0));
        cap_n = 0;
        @(negedge clk);
        ind_en = 1'b1;
        @(negedge clk);
        chk(rd_ptr == 40'h3000 && end_ptr == 40'h3000, "R7 empty loaded", 64'(rd_ptr),
            64'h3000);
        @(negedge clk);
        chk(rd_ptr == 40'h4000, "R7 next loaded", 64'(rd_ptr), 64'h4000);
        drain(1, "R7 count");
        chk_words(40'h00_0000_4000, 0, 1, "R7 word");

        // R8: fill queue, then push while full in the cycle a load pops.
        @(negedge clk);
        ind_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) push_ent(mk(40'h5000 + 40'(k * 256), 21'd1, 1'b0));
        chk(ent_q_full == 1'b1 && ent_q_empty == 1'b0, "R8 full flag", 64'(ent_q_full),
            64'd1);
        cap_n = 0;
        @(negedge clk);
        ind_en         = 1'b1;
        ent_push_valid = 1'b1;
        ent_push_data  = mk(40'h0000_9000, 21'd1, 1'b0);
        @(negedge clk);
        ent_push_valid = 1'b0;
        drain(DEPTH, "R8 refused push not delivered");
        for (int k = 0; k < DEPTH; k++) chk_words(40'h5000 + 40'(k * 256), k, 1, "R8 order");
        chk(ent_q_empty == 1'b1 && ent_q_full == 1'b0, "R8 empty after drain",
            64'(ent_q_empty), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule